// File: doc/BRIEF.md
# Display Controller Parallel Bus Host

This block connects an internal request port to a display controller over an asynchronous 16-bit parallel bus in the 8080 style. The bus has separate active-low read and write strobes, an active-low chip select and a register-select line. A requester sends one request at a time. A request is one of three kinds: an index write, which selects a controller register; a data write, which stores a value in the selected register; or a data read, which returns the contents of the selected register.

Every bus cycle runs through the same three phases. First comes an address-setup phase, with chip select low and both strobes high. Next comes a strobe phase, with the selected strobe held low. Last comes a single hold cycle, in which the strobe is back high and chip select is still low. Reads and writes each take their own pair of phase lengths from input ports. These lengths are sampled when the request is accepted, so a slow read timing and a fast write timing can be used in turn without any reconfiguration. No wait or ready signal from the display is observed. The phase lengths alone fix the length of a cycle.

Top module: `pbus_if`

## Requirements
- R1: While reset is held, and on the first cycle after it, `req_ready` is 1, `bus_cs_n`, `bus_wr_n` and `bus_rd_n` are 1, and `done` is 0.
- R2: `req_kind` 0 is an index write and drives `bus_rs` low. 1 is a data write and drives `bus_rs` high. 2 and 3 are data reads and drive `bus_rs` high. `bus_rs` holds one value for the whole chip-select-low window.
- R3: Chip select goes low on the cycle after the request is accepted. Both strobes then stay high for max(A,1) cycles. A is `rd_addr_cyc` for reads and `wr_addr_cyc` for writes.
- R4: The strobe for the direction of the request is then low for max(D,1) consecutive cycles. D is `rd_data_cyc` or `wr_data_cyc`. The other strobe never goes low, and both strobes are never low together.
- R5: After the strobe rises, chip select stays low for exactly one more cycle and then returns high. The chip-select-low window therefore lasts max(A,1)+max(D,1)+1 cycles.
- R6: During a write, `bus_dout` equals the accepted write word and `bus_oe` is 1 for the whole chip-select-low window. During a read, `bus_oe` is 0.
- R7: A read captures `bus_din` as it stands in the last strobe-low cycle. The captured value appears on `rdata` in the `done` cycle and stays there until the next read completes.
- R8: `done` is high for exactly one cycle, the hold cycle. `req_ready` is low from the cycle after acceptance through the hold cycle. Any request presented while `req_ready` is low is ignored and leaves no effect on the bus.
- R9: The timing inputs are sampled only at acceptance. Changing them during a cycle does not change that cycle.
- R10: With the default timings (read 30/30, write 3/3), a read holds chip select low for 61 cycles and a write holds it low for 7 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; accepted when `req_ready` is 1 |
| req_kind | input | 2 | 0 index write, 1 data write, 2 or 3 data read |
| req_wdata | input | 16 | Word for index and data writes |
| rd_addr_cyc | input | 8 | Address-setup cycles for reads (0 acts as 1) |
| rd_data_cyc | input | 8 | Strobe-low cycles for reads (0 acts as 1) |
| wr_addr_cyc | input | 8 | Address-setup cycles for writes (0 acts as 1) |
| wr_data_cyc | input | 8 | Strobe-low cycles for writes (0 acts as 1) |
| req_ready | output | 1 | No cycle in progress |
| done | output | 1 | One-cycle pulse in the hold cycle |
| rdata | output | 16 | Most recent read result |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rs | output | 1 | Register select: 0 index, 1 data |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_dout | output | 16 | Write data toward the display |
| bus_oe | output | 1 | Output enable for `bus_dout` |
| bus_din | input | 16 | Read data from the display |

## Verification
If a request is accepted at edge E0, the setup phase is visible after E0 and the strobe phase after edge E0+max(A,1). The read word is captured at edge E0+max(A,1)+max(D,1), and `done` and `rdata` are visible in the hold cycle that follows. `req_ready` returns one edge later. The bench samples every output on the falling clock edge, one sample per bus cycle, and measures the length of each phase by counting those samples. It compares the counts with the clamped setting values. The display model in the bench presents the correct read word only in the last strobe-low cycle, so a capture made on any other edge returns a wrong value.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    typedef enum logic [1:0] {
        OP_INDEX = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    // Default phase lengths in clocks
    localparam int RD_ADDR_DEF = 30;
    localparam int RD_DATA_DEF = 30;
    localparam int WR_ADDR_DEF = 3;
    localparam int WR_DATA_DEF = 3;

    // Request kind to operation: bit 1 selects read, else bit 0 selects data
    function automatic op_e decode_kind(logic [1:0] kind);
        if (kind[1])      return OP_READ;
        else if (kind[0]) return OP_WRITE;
        else              return OP_INDEX;
    endfunction

endpackage

// File: rtl/pbus_timer.sv
module pbus_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [TW-1:0] val_i,
    output logic          last_o
);

    logic [TW-1:0] cnt_q;

    // A zero setting is clamped to one cycle
    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= (val_i == '0) ? TW'(1) : val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - TW'(1);
    end

    assign last_o = (cnt_q == TW'(1));

    // R3 R4: a freshly loaded phase always lasts at least one cycle
    a_r3_load_nonzero: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cnt_q != '0));

endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
    import pbus_pkg::*;
#(
    parameter int DW = 16,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept_i,
    input  op_e           op_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [TW-1:0] acyc_i,
    input  logic [TW-1:0] dcyc_i,
    input  logic          tmr_last_i,
    output logic          tmr_load_o,
    output logic [TW-1:0] tmr_val_o,
    output logic          ready_o,
    output logic          done_o,
    output logic [DW-1:0] rdata_o,
    output logic          cs_n_o,
    output logic          rs_o,
    output logic          wr_n_o,
    output logic          rd_n_o,
    output logic [DW-1:0] dout_o,
    output logic          oe_o,
    input  logic [DW-1:0] din_i
);

    typedef struct packed {
        op_e           op;
        logic [DW-1:0] wdata;
        logic [TW-1:0] dcyc;
    } cmd_t;

    phase_e        phase_q, phase_d;
    cmd_t          cmd_q;
    logic [DW-1:0] rdata_q;
    logic          is_read;

    assign is_read = (cmd_q.op == OP_READ);

    always_comb begin
        phase_d    = phase_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = acyc_i;
        case (phase_q)
            PH_IDLE: if (accept_i) begin
                phase_d    = PH_SETUP;
                tmr_load_o = 1'b1;
            end
            PH_SETUP: if (tmr_last_i) begin
                phase_d    = PH_STROBE;
                tmr_load_o = 1'b1;
                tmr_val_o  = cmd_q.dcyc;
            end
            PH_STROBE: if (tmr_last_i) phase_d = PH_HOLD;
            default:   phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cmd_q   <= '0;
            rdata_q <= '0;
        end else begin
            phase_q <= phase_d;
            if (accept_i && phase_q == PH_IDLE)
                cmd_q <= '{op: op_i, wdata: wdata_i, dcyc: dcyc_i};
            if (phase_q == PH_STROBE && tmr_last_i && is_read)
                rdata_q <= din_i;
        end
    end

    assign ready_o = (phase_q == PH_IDLE);
    assign done_o  = (phase_q == PH_HOLD);
    assign cs_n_o  = (phase_q == PH_IDLE);
    assign rs_o    = (cmd_q.op != OP_INDEX);
    assign wr_n_o  = !(phase_q == PH_STROBE && !is_read);
    assign rd_n_o  = !(phase_q == PH_STROBE && is_read);
    assign oe_o    = (phase_q != PH_IDLE) && !is_read;
    assign dout_o  = cmd_q.wdata;
    assign rdata_o = rdata_q;

    // R4: never both strobes low
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (rst)
        !(!wr_n_o && !rd_n_o));

    // R4: a strobe is only ever low inside a chip-select window
    a_r4_strobe_in_cs: assert property (@(posedge clk) disable iff (rst)
        (!wr_n_o || !rd_n_o) |-> !cs_n_o);

    // R5: the cycle after a strobe rises is a hold cycle with done
    a_r5_hold_after_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_n_o && rd_n_o) |-> (!cs_n_o && done_o));

    // R8: done is a single pulse followed by ready
    a_r8_done_then_ready: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (ready_o && !done_o));

    // R8: acceptance starts a busy bus cycle
    a_r8_accept_busy: assert property (@(posedge clk) disable iff (rst)
        accept_i |=> (!ready_o && !cs_n_o));

    // R2: register select is steady across a chip-select window
    a_r2_rs_stable: assert property (@(posedge clk) disable iff (rst)
        (!cs_n_o && !$past(cs_n_o)) |-> $stable(rs_o));

    // R7: read result only moves in the done cycle
    a_r7_rdata_update: assert property (@(posedge clk) disable iff (rst)
        !$stable(rdata_o) |-> done_o);

endmodule

// File: rtl/pbus_if.sv
module pbus_if
    import pbus_pkg::*;
#(
    parameter int DW = 16,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic [DW-1:0] req_wdata,
    input  logic [TW-1:0] rd_addr_cyc,
    input  logic [TW-1:0] rd_data_cyc,
    input  logic [TW-1:0] wr_addr_cyc,
    input  logic [TW-1:0] wr_data_cyc,
    output logic          req_ready,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic          bus_cs_n,
    output logic          bus_rs,
    output logic          bus_wr_n,
    output logic          bus_rd_n,
    output logic [DW-1:0] bus_dout,
    output logic          bus_oe,
    input  logic [DW-1:0] bus_din
);

    op_e           req_op;
    logic          accept;
    logic [TW-1:0] sel_acyc, sel_dcyc;
    logic          tmr_load, tmr_last;
    logic [TW-1:0] tmr_val;

    assign req_op   = decode_kind(req_kind);
    assign accept   = req_valid && req_ready;
    assign sel_acyc = (req_op == OP_READ) ? rd_addr_cyc : wr_addr_cyc;
    assign sel_dcyc = (req_op == OP_READ) ? rd_data_cyc : wr_data_cyc;

    pbus_timer #(.TW(TW)) timer_i (
        .clk    (clk),
        .rst    (rst),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .last_o (tmr_last)
    );

    pbus_seq #(.DW(DW), .TW(TW)) seq_i (
        .clk        (clk),
        .rst        (rst),
        .accept_i   (accept),
        .op_i       (req_op),
        .wdata_i    (req_wdata),
        .acyc_i     (sel_acyc),
        .dcyc_i     (sel_dcyc),
        .tmr_last_i (tmr_last),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .ready_o    (req_ready),
        .done_o     (done),
        .rdata_o    (rdata),
        .cs_n_o     (bus_cs_n),
        .rs_o       (bus_rs),
        .wr_n_o     (bus_wr_n),
        .rd_n_o     (bus_rd_n),
        .dout_o     (bus_dout),
        .oe_o       (bus_oe),
        .din_i      (bus_din)
    );

    // R9: a request is taken only when idle
    a_r9_accept_idle: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> $stable(bus_rs) || bus_cs_n);

endmodule

// File: tb/pbus_if_tb_top.sv
module pbus_if_tb_top;
    import pbus_pkg::*;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [15:0] req_wdata = 16'h0;
    logic [7:0]  rd_addr_cyc = 8'd1, rd_data_cyc = 8'd1;
    logic [7:0]  wr_addr_cyc = 8'd1, wr_data_cyc = 8'd1;
    logic        req_ready, done, bus_cs_n, bus_rs, bus_wr_n, bus_rd_n, bus_oe;
    logic [15:0] rdata, bus_dout, bus_din;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int cur_d = 1;
    int last_cs_len = 0;

    // Display model
    logic [15:0] m_mem [16];
    logic [3:0]  m_idx = 4'd0;
    int          rd_low_n = 0;
    // Shadow state kept by the bench
    logic [15:0] s_mem [16];
    logic [3:0]  s_idx = 4'd0;

    always #(CLK_P/2) clk = ~clk;

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_mem[i] = 16'h0;
            s_mem[i] = 16'h0;
        end
    end

    always @(posedge bus_wr_n) begin
        if (bus_cs_n === 1'b0) begin
            if (!bus_rs) m_idx <= bus_dout[3:0];
            else         m_mem[m_idx] <= bus_dout;
        end
    end

    always @(posedge clk) begin
        if (bus_rd_n === 1'b0) rd_low_n <= rd_low_n + 1;
        else                   rd_low_n <= 0;
    end

    // Correct word only in the last strobe-low cycle
    assign bus_din = (bus_rd_n === 1'b0 && rd_low_n == cur_d - 1) ? m_mem[m_idx] : 16'hDEAD;

    pbus_if dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_wdata(req_wdata), .rd_addr_cyc(rd_addr_cyc), .rd_data_cyc(rd_data_cyc),
        .wr_addr_cyc(wr_addr_cyc), .wr_data_cyc(wr_data_cyc), .req_ready(req_ready),
        .done(done), .rdata(rdata), .bus_cs_n(bus_cs_n), .bus_rs(bus_rs),
        .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_dout(bus_dout),
        .bus_oe(bus_oe), .bus_din(bus_din)
    );

    function automatic int eff(int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] k, input logic [15:0] wd, input int a,
                          input int d, input bit poke);
        int sc = 0, stc = 0, hc = 0, dc = 0;
        int busy_rdy = 0, rs_bad = 0, out_bad = 0, wrong = 0;
        bit seen_cs = 0, seen_st = 0, in_hold_done = 0, poked = 0;
        bit slow, olow;
        logic [15:0] rd_at_done = 16'h0;
        logic [15:0] exp_rd;
        exp_rd = s_mem[s_idx];
        @(negedge clk);
        chk(req_ready == 1'b1, "R8 ready before request", int'(req_ready), 1);
        req_valid = 1'b1; req_kind = k; req_wdata = wd;
        if (k[1]) begin
            rd_addr_cyc = 8'(a); rd_data_cyc = 8'(d);
            wr_addr_cyc = 8'(a + 7); wr_data_cyc = 8'(d + 9);
        end else begin
            wr_addr_cyc = 8'(a); wr_data_cyc = 8'(d);
            rd_addr_cyc = 8'(a + 7); rd_data_cyc = 8'(d + 9);
        end
        cur_d = eff(d);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (i == 0) begin
                // R9: change every timing input after acceptance
                req_valid = 1'b0;
                rd_addr_cyc = 8'(a + 2); rd_data_cyc = 8'(d + 3);
                wr_addr_cyc = 8'(a + 4); wr_data_cyc = 8'(d + 5);
            end
            if (poked) begin
                req_valid = 1'b0;
                poked = 0;
            end
            if (bus_cs_n && seen_cs) break;
            if (!bus_cs_n) seen_cs = 1;
            slow = k[1] ? !bus_rd_n : !bus_wr_n;
            olow = k[1] ? !bus_wr_n : !bus_rd_n;
            if (olow) wrong++;
            if (!bus_cs_n) begin
                if (req_ready) busy_rdy++;
                if (bus_rs != (k != 2'd0)) rs_bad++;
                if (!k[1] && (bus_dout != wd || !bus_oe)) out_bad++;
                if (k[1] && bus_oe) out_bad++;
                if (slow) begin stc++; seen_st = 1; end
                else if (!seen_st) sc++;
                else hc++;
            end
            if (done) begin
                dc++;
                if (seen_st && !slow && !bus_cs_n) begin
                    in_hold_done = 1;
                    rd_at_done = rdata;
                end
            end
            if (poke && slow && stc == 1) begin
                req_valid = 1'b1; req_kind = 2'd0; req_wdata = 16'h000F;
                poked = 1;
            end
        end
        last_cs_len = sc + stc + hc;
        chk(sc == eff(a), "R3 R9 setup length", sc, eff(a));
        chk(stc == eff(d), "R4 R9 strobe length", stc, eff(d));
        chk(wrong == 0, "R4 wrong strobe cycles", wrong, 0);
        chk(hc == 1, "R5 hold length", hc, 1);
        chk(rs_bad == 0, "R2 register select errors", rs_bad, 0);
        chk(out_bad == 0, "R6 output data errors", out_bad, 0);
        chk(dc == 1 && in_hold_done, "R8 done pulses in hold", dc, 1);
        chk(busy_rdy == 0, "R8 ready while busy", busy_rdy, 0);
        chk(req_ready == 1'b1, "R8 ready after cycle", int'(req_ready), 1);
        if (k[1]) begin
            chk(rd_at_done == exp_rd, "R7 read word at done", int'(rd_at_done), int'(exp_rd));
            chk(rdata == exp_rd, "R7 read word held", int'(rdata), int'(exp_rd));
        end
        if (k == 2'd0) s_idx = wd[3:0];
        if (k == 2'd1) s_mem[s_idx] = wd;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
        chk(bus_cs_n && bus_wr_n && bus_rd_n, "R1 bus idle in reset", int'({bus_cs_n, bus_wr_n, bus_rd_n}), 7);
        chk(done == 1'b0, "R1 done low in reset", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && bus_cs_n && !done, "R1 state after reset", int'({req_ready, bus_cs_n, done}), 6);

        // Sweep of phase settings 0..3 for every request kind
        for (int a = 0; a < 4; a++) begin
            for (int d = 0; d < 4; d++) begin
                int n = a * 4 + d;
                run_op(2'd0, 16'(n), a, d, 1'b0);
                run_op(2'd1, 16'hA5C3 ^ 16'(n * 16'h1111), d, a, 1'b0);
                run_op((n % 2 == 1) ? 2'd3 : 2'd2, 16'h0, a, d, 1'b0);
            end
        end

        // R10: default timings
        run_op(2'd0, 16'h0005, WR_ADDR_DEF, WR_DATA_DEF, 1'b0);
        chk(last_cs_len == 7, "R10 default write window", last_cs_len, 7);
        run_op(2'd2, 16'h0, RD_ADDR_DEF, RD_DATA_DEF, 1'b0);
        chk(last_cs_len == 61, "R10 default read window", last_cs_len, 61);

        // R8: index write presented while busy is ignored
        run_op(2'd0, 16'h0002, 1, 2, 1'b0);
        run_op(2'd1, 16'h1234, 1, 1, 1'b0);
        run_op(2'd2, 16'h0, 2, 3, 1'b1);
        run_op(2'd2, 16'h0, 1, 1, 1'b0);
        chk(rdata == 16'h1234, "R8 busy request ignored", int'(rdata), 16'h1234);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule